// File: doc/BRIEF.md
# Logarithmic Multi-Mode Word Shifter

This block shifts a 32-bit data word by any distance from 0 to 31 positions in a single pass of combinational logic. A 2-bit mode input picks the kind of shift: left with zero fill, right with zero fill, or right with the sign bit replicated into the vacated upper positions. There is no clock inside the block. The result follows the inputs within the same cycle, so it can sit between two register stages of a datapath.

Inside, the shift distance is decomposed into its binary digits. One layer of 2:1 multiplexers is assigned to each digit. Layer k either passes its word straight through or moves it right by 2^k positions, so five layers cover every distance for a 32-bit word. A left shift reuses the same right-moving layers: the word is mirrored before the first layer and mirrored back after the last. The fill bit injected at the top of each layer is zero, except in arithmetic mode, where it is the most significant bit of the original input word.

Top module: `log_shifter`

## Requirements
- R1: When `shamt` is 0, `data_out` equals `data_in` in every mode.
- R2: Mode 2'b00 shifts left: `data_out` is `data_in` moved up by `shamt` places, and the `shamt` lowest bits are 0.
- R3: Mode 2'b01 shifts right logically: `data_out` is `data_in` moved down by `shamt` places, and the `shamt` highest bits are 0.
- R4: Mode 2'b10 shifts right arithmetically: `data_out` is `data_in` moved down by `shamt` places, and the `shamt` highest bits are copies of `data_in[31]`.
- R5: Mode 2'b11 gives exactly the same result as mode 2'b01 for every word and distance.
- R6: Every distance from 0 to 31 is honoured, including the extreme of 31. For that distance, a left shift leaves `data_in[0]` alone at bit 31, and an arithmetic right shift returns 32 copies of `data_in[31]`.
- R7: The block holds no state. A change on any input appears on `data_out` without any clock edge.
- R8: The arithmetic fill bit always comes from bit 31 of the input word. It does not depend on any intermediate layer. For example, 0x80000000 shifted arithmetically by 31 gives 0xFFFFFFFF, and 0x7FFFFFFF gives 0x00000000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| data_in | input | 32 | Word to be shifted |
| shamt | input | 5 | Shift distance, 0 to 31 |
| mode | input | 2 | 00 left logical, 01 right logical, 10 right arithmetic, 11 right logical |
| data_out | output | 32 | Shifted word |

## Verification
Every result is due in the same cycle as its stimulus, because no register lies between the inputs and the output. The driver changes the inputs just after a rising edge and queues the expected word. The monitor takes that word from the queue and compares it at the following falling edge, half a period later, by which time the mux layers have settled. The check for R7 changes the inputs while the clock is quiet and reads the output after a small delay, with no edge in between.

// File: rtl/shf_pkg.sv
// Package of shared definitions for the logarithmic shifter.
// Assumes a 2-bit mode field; the spare code is decoded as a logical right shift.
package shf_pkg;

    typedef enum logic [1:0] {
        SHF_LEFT  = 2'b00,
        SHF_RLOG  = 2'b01,
        SHF_RARI  = 2'b10,
        SHF_SPARE = 2'b11
    } shf_mode_e;

endpackage

// File: rtl/shf_mirror.sv
// Conditional bit mirror: when en is high, output bit i takes input bit WIDTH-1-i.
// Assumes WIDTH >= 2. Built only from per-bit 2:1 multiplexers.
module shf_mirror #(
    parameter int WIDTH = 32
) (
    input  logic             en,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    // Per-bit choice between the straight bit and its mirrored partner
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        assign dout[i] = en ? din[WIDTH-1-i] : din[i];
    end

endmodule

// File: rtl/shf_layer.sv
// One shifter layer: when sel is high, the word moves right by DIST places and the
// vacated top bits take the fill value; otherwise the word passes unchanged.
// Assumes 0 < DIST < WIDTH. Only 2:1 multiplexers and wiring.
module shf_layer #(
    parameter int WIDTH = 32,
    parameter int DIST  = 1
) (
    input  logic             sel,
    input  logic             fill,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    // Each output bit picks its own input bit or the one DIST places above it
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        if (i + DIST < WIDTH) begin : g_body
            assign dout[i] = sel ? din[i+DIST] : din[i];
        end else begin : g_edge
            assign dout[i] = sel ? fill : din[i];
        end
    end

endmodule

// File: rtl/shf_mode_dec.sv
// Mode decoder: says whether the word must be mirrored (left shift) and which
// bit value enters from the top of each layer.
// Assumes the arithmetic fill comes from the top bit of the original input word.
module shf_mode_dec (
    input  logic [1:0] mode,
    input  logic       src_msb,
    output logic       mirror,
    output logic       fill
);
    import shf_pkg::*;

    shf_mode_e md;

    // Decode the mode into mirror control and fill value
    always_comb begin
        md     = shf_mode_e'(mode);
        mirror = (md == SHF_LEFT);
        fill   = (md == SHF_RARI) ? src_msb : 1'b0;
    end

endmodule

// File: rtl/log_shifter.sv
// Top of the combinational logarithmic shifter. The input is optionally mirrored,
// passed through one right-moving layer per shift-distance bit, then mirrored back.
// Assumes WIDTH is a power of two; no clock or reset, the output follows the inputs.
module log_shifter #(
    parameter int WIDTH = 32,
    localparam int SHW  = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] data_in,
    input  logic [SHW-1:0]   shamt,
    input  logic [1:0]       mode,
    output logic [WIDTH-1:0] data_out
);

    logic                       mirror;
    logic                       fill;
    logic [SHW:0][WIDTH-1:0]    lane;

    shf_mode_dec u_dec (
        .mode    (mode),
        .src_msb (data_in[WIDTH-1]),
        .mirror  (mirror),
        .fill    (fill)
    );

    shf_mirror #(.WIDTH(WIDTH)) u_pre (
        .en   (mirror),
        .din  (data_in),
        .dout (lane[0])
    );

    // One layer per bit of the shift distance; layer k moves by 2^k
    for (genvar k = 0; k < SHW; k++) begin : g_layer
        shf_layer #(.WIDTH(WIDTH), .DIST(1 << k)) u_layer (
            .sel  (shamt[k]),
            .fill (fill),
            .din  (lane[k]),
            .dout (lane[k+1])
        );
    end

    shf_mirror #(.WIDTH(WIDTH)) u_post (
        .en   (mirror),
        .din  (lane[SHW]),
        .dout (data_out)
    );

endmodule

// File: rtl/log_shifter_chk.sv
// Checker for log_shifter: port-level properties of each mode, evaluated whenever
// the inputs or output change. Assumes the encodings stated in the brief.
module log_shifter_chk #(
    parameter int WIDTH = 32,
    localparam int SHW  = $clog2(WIDTH)
) (
    input logic [WIDTH-1:0] data_in,
    input logic [SHW-1:0]   shamt,
    input logic [1:0]       mode,
    input logic [WIDTH-1:0] data_out
);

    logic [WIDTH-1:0] hi_mask;
    logic [WIDTH-1:0] lo_mask;
    logic             known;

    // Masks of the bit positions vacated by a shift of shamt places
    always_comb begin
        hi_mask = ~({WIDTH{1'b1}} >> shamt);
        lo_mask = ~({WIDTH{1'b1}} << shamt);
        known   = !$isunknown({data_in, shamt, mode, data_out});
    end

    // Immediate checks on the port relations
    always_comb begin
        if (known) begin
            // R1
            amt_zero_chk: assert (shamt != '0 || data_out == data_in);
            // R2
            left_fill_chk: assert (mode != 2'b00 || (data_out & lo_mask) == '0);
            // R2
            left_move_chk: assert (mode != 2'b00 || data_out[shamt] == data_in[0]);
            // R3
            rlog_fill_chk: assert (mode[1] || mode == 2'b00 || (data_out & hi_mask) == '0);
            // R4
            rari_fill_chk: assert (mode != 2'b10 ||
                (data_out & hi_mask) == (data_in[WIDTH-1] ? hi_mask : '0));
            // R8
            right_move_chk: assert (mode == 2'b00 ||
                data_out[WIDTH-1-shamt] == data_in[WIDTH-1]);
        end
    end

endmodule

bind log_shifter log_shifter_chk #(.WIDTH(WIDTH)) u_chk (
    .data_in  (data_in),
    .shamt    (shamt),
    .mode     (mode),
    .data_out (data_out)
);

// File: tb/log_shifter_test.sv
module log_shifter_test;

    localparam int CLK_PERIOD = 10;
    localparam int W          = 32;
    localparam int WDOG       = 20000;

    logic          clk = 1'b0;
    logic [W-1:0]  data_in = '0;
    logic [4:0]    shamt = '0;
    logic [1:0]    mode = '0;
    logic [W-1:0]  data_out;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    logic [W-1:0] exp_q [$];
    string        tag_q [$];

    log_shifter uut (
        .data_in  (data_in),
        .shamt    (shamt),
        .mode     (mode),
        .data_out (data_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Reference model written from the requirements
    function automatic logic [W-1:0] model(input logic [W-1:0] d, input logic [4:0] s,
                                           input logic [1:0] m);
        case (m)
            2'b00:   return d << s;
            2'b10:   return W'($signed(d) >>> s);
            default: return d >> s;
        endcase
    endfunction

    function automatic string tag_of(input logic [4:0] s, input logic [1:0] m);
        if (s == 0) return "R1";
        case (m)
            2'b00:   return "R2";
            2'b01:   return "R3";
            2'b10:   return "R4";
            default: return "R5";
        endcase
    endfunction

    // Driver: apply one stimulus after a rising edge and queue its expectation
    task automatic send(input logic [W-1:0] d, input logic [4:0] s, input logic [1:0] m,
                        input logic [W-1:0] exp, input string tag);
        @(posedge clk);
        #1;
        data_in = d;
        shamt   = s;
        mode    = m;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
    endtask

    task automatic send_auto(input logic [W-1:0] d, input logic [4:0] s, input logic [1:0] m);
        send(d, s, m, model(d, s, m), tag_of(s, m));
    endtask

    // Monitor: compare the output with the oldest expectation at the falling edge
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            logic [W-1:0] e;
            string        t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            total++;
            if (data_out !== e) begin
                bad++;
                $display("FAIL %s din=%h sh=%0d mode=%0d actual=%h expected=%h",
                         t, data_in, shamt, mode, data_out, e);
            end
        end
    end

    // Watchdog
    initial begin
        repeat (WDOG) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog R7 actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // Idle state: all-zero inputs give zero
        send(32'h0, 5'd0, 2'b00, 32'h0, "R1");

        // R1: zero distance leaves the word alone in every mode
        for (int m = 0; m < 4; m++) send(32'hA5C3_0F96, 5'd0, 2'(m), 32'hA5C3_0F96, "R1");

        // R6: extreme distance of 31
        send(32'h0000_0001, 5'd31, 2'b00, 32'h8000_0000, "R6");
        send(32'hFFFF_FFFE, 5'd31, 2'b00, 32'h0000_0000, "R6");
        send(32'h8000_0000, 5'd31, 2'b01, 32'h0000_0001, "R6");

        // R8: fill from the input top bit
        send(32'h8000_0000, 5'd31, 2'b10, 32'hFFFF_FFFF, "R8");
        send(32'h7FFF_FFFF, 5'd31, 2'b10, 32'h0000_0000, "R8");
        send(32'h8000_0000, 5'd4,  2'b10, 32'hF800_0000, "R8");
        send(32'hC000_0001, 5'd17, 2'b10, 32'hFFFF_E000, "R8");

        // R3 vs R4 on a negative word, R5 mirrors R3
        send(32'hF000_000F, 5'd8, 2'b01, 32'h00F0_0000, "R3");
        send(32'hF000_000F, 5'd8, 2'b10, 32'hFFF0_0000, "R4");
        send(32'hF000_000F, 5'd8, 2'b11, 32'h00F0_0000, "R5");
        send(32'hF000_000F, 5'd8, 2'b00, 32'h0000_0F00, "R2");

        // Sweep: every distance in every mode for several random words
        for (int w = 0; w < 8; w++) begin
            logic [W-1:0] d;
            d = $urandom();
            if (w == 0) d = 32'hFFFF_FFFF;
            if (w == 1) d = 32'h8000_0001;
            for (int m = 0; m < 4; m++)
                for (int s = 0; s < 32; s++)
                    send_auto(d, 5'(s), 2'(m));
        end

        // Drain the scoreboard
        @(posedge clk);
        wait (exp_q.size() == 0);

        // R7: output follows inputs without any clock edge
        @(negedge clk);
        #1;
        data_in = 32'h1234_5678;
        shamt   = 5'd4;
        mode    = 2'b00;
        #1;
        total++;
        if (data_out !== 32'h2345_6780) begin
            bad++;
            $display("FAIL R7 actual=%h expected=%h", data_out, 32'h2345_6780);
        end
        mode = 2'b01;
        #1;
        total++;
        if (data_out !== 32'h0123_4567) begin
            bad++;
            $display("FAIL R7 actual=%h expected=%h", data_out, 32'h0123_4567);
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule